// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block carries out the program-counter and stack-pointer side of subroutine control flow. It handles near and far calls, restarts to fixed vectors, counted loops, long jumps and the two matching kinds of return. It holds a 16-bit program counter, a 16-bit stack pointer, an 8-bit extended page register and an 8-bit restart base register. A decoder, which is not part of this block, presents one command with its immediate operands. The sequencer then drives a byte-wide synchronous memory port with a fixed series of single-byte writes or reads, one per clock, and moves its registers to their final values.

A far call or far return moves one more byte than its near form: the page byte. A restart pushes the return address in the same way as a near call and jumps to an address whose high byte is the restart base and whose low byte is the vector. Only five vector values are legal. The counted loop takes the loop counter on `b_in`, returns the decremented value on `b_out`, and branches by a signed byte when that value is not zero.

A one-cycle `done` pulse reports that the registers hold their final values. Another command may be presented in that same cycle.

Top module: `stack_seq`

## Requirements
- R1: After reset, pc, sp, page and rst_base are 0. busy, done, err and b_wr are low, and neither mem_we nor mem_re is asserted.
- R2: Near call (cmd_op=1) writes pc[15:8] to sp-1 in the first busy cycle and pc[7:0] to sp-2 in the second. It then sets pc to cmd_target and lowers sp by 2.
- R3: Far call (cmd_op=2) writes page to sp-1, then pc[15:8] to sp-2, then pc[7:0] to sp-3, one write per cycle. It then sets page to cmd_page, sets pc to cmd_target and lowers sp by 3.
- R4: Near return (cmd_op=3) reads sp and then sp+1 in consecutive cycles. The first byte read becomes pc[7:0] and the second becomes pc[15:8]. sp rises by 2.
- R5: Far return (cmd_op=4) reads sp, sp+1 and sp+2 in consecutive cycles, giving pc[7:0], pc[15:8] and page in that order. sp rises by 3.
- R6: Restart (cmd_op=5) with cmd_vec equal to 10h, 18h, 20h, 28h or 38h pushes pc in the same way as a near call. It then sets pc to {rst_base, cmd_vec} and lowers sp by 2.
- R7: Restart with any other cmd_vec is ignored. There is no memory access, pc, sp and page do not change, busy stays low, and err is high for exactly the one cycle after the command.
- R8: Counted loop (cmd_op=6) drives b_out=b_in-1 (mod 256) with b_wr high in the done cycle. If that value is nonzero, pc becomes pc plus sign-extended cmd_disp (mod 2^16); otherwise pc is unchanged. The loop makes no memory access.
- R9: Long jump (cmd_op=7) sets page to cmd_page and pc to cmd_target. It makes no memory access and leaves sp unchanged.
- R10: Stack set (cmd_op=8) loads sp from cmd_target. Base set (cmd_op=9) loads rst_base from cmd_page. Neither makes a memory access.
- R11: busy is high from the cycle after acceptance. Each stack byte takes one busy cycle. A read-based command adds one busy cycle after its last read, and a command with no access has one busy cycle. done is high for exactly one cycle, right after the last busy cycle, and busy is low in that cycle.
- R12: A command presented while busy is ignored. A command presented in the done cycle is accepted. Codes 0 and 10 to 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_target | input | 16 | Target address, or new stack pointer |
| cmd_page | input | 8 | New page, or new restart base |
| cmd_vec | input | 8 | Restart vector |
| cmd_disp | input | 8 | Signed loop displacement |
| b_in | input | 8 | Loop counter value before decrement |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is returned the next cycle |
| mem_rdata | input | 8 | Memory read byte |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| page | output | 8 | Extended page register |
| rst_base | output | 8 | Restart base register |
| b_out | output | 8 | Decremented loop counter |
| b_wr | output | 1 | b_out is valid this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Registers are final (one-cycle pulse) |
| err | output | 1 | Illegal restart vector (one-cycle pulse) |

## Verification
Two functions can meet in one cycle: the completion of one command and the acceptance of the next. The done pulse and a fresh cmd_valid coincide there. The bench presents every command in the done cycle of the one before it. It then judges that the next cycle is busy and that the new sequence addresses the stack from the stack pointer the previous command just left. The bench also provokes the opposite overlap, a command offered in the middle of a call. It judges from the final stack pointer and from a low busy after done that the offered command had no effect.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_CALL    = 4'd1,
    OP_FCALL   = 4'd2,
    OP_RET     = 4'd3,
    OP_FRET    = 4'd4,
    OP_RST     = 4'd5,
    OP_LOOP    = 4'd6,
    OP_FJMP    = 4'd7,
    OP_SETSP   = 4'd8,
    OP_SETBASE = 4'd9
  } op_e;

  // Legal restart vectors.
  function automatic logic vec_legal(input logic [BYTE_W-1:0] v);
    return (v == 8'h10) || (v == 8'h18) || (v == 8'h20) ||
           (v == 8'h28) || (v == 8'h38);
  endfunction

  // Busy cycles per command; 0 marks an unknown code.
  function automatic logic [STEP_W-1:0] op_steps(input op_e op);
    case (op)
      OP_CALL, OP_RST:                      return STEP_W'(2);
      OP_FCALL, OP_RET:                     return STEP_W'(3);
      OP_FRET:                              return STEP_W'(4);
      OP_LOOP, OP_FJMP, OP_SETSP, OP_SETBASE: return STEP_W'(1);
      default:                              return STEP_W'(0);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] below_sp(input logic [ADDR_W-1:0] s,
                                                 input logic [STEP_W-1:0] k);
    return s - ADDR_W'(k) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] above_sp(input logic [ADDR_W-1:0] s,
                                                 input logic [STEP_W-1:0] k);
    return s + ADDR_W'(k);
  endfunction

  function automatic logic [ADDR_W-1:0] branch_pc(input logic [ADDR_W-1:0] p,
                                                  input logic [BYTE_W-1:0] d);
    return p + {{(ADDR_W-BYTE_W){d[BYTE_W-1]}}, d};
  endfunction
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] n_steps,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              last,
  output logic              done
);
  logic [STEP_W-1:0] nst_q;

  assign last = busy && (step == nst_q - STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      nst_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy  <= 1'b1;
        step  <= '0;
        nst_q <= n_steps;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/stack_seq_port.sv
module stack_seq_port
  import stack_seq_pkg::*;
(
  input  logic              busy,
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] sp,
  input  logic [BYTE_W-1:0] page,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we,
  output logic              re
);
  always_comb begin
    addr  = '0;
    wdata = '0;
    we    = 1'b0;
    re    = 1'b0;
    if (busy) begin
      case (op)
        OP_CALL, OP_RST: begin
          if (step < STEP_W'(2)) begin
            we    = 1'b1;
            addr  = below_sp(sp, step);
            wdata = (step == '0) ? pc[ADDR_W-1:BYTE_W] : pc[BYTE_W-1:0];
          end
        end
        OP_FCALL: begin
          if (step < STEP_W'(3)) begin
            we   = 1'b1;
            addr = below_sp(sp, step);
            case (step)
              STEP_W'(0): wdata = page;
              STEP_W'(1): wdata = pc[ADDR_W-1:BYTE_W];
              default:    wdata = pc[BYTE_W-1:0];
            endcase
          end
        end
        OP_RET: begin
          if (step < STEP_W'(2)) begin
            re   = 1'b1;
            addr = above_sp(sp, step);
          end
        end
        OP_FRET: begin
          if (step < STEP_W'(3)) begin
            re   = 1'b1;
            addr = above_sp(sp, step);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic [BYTE_W-1:0] cmd_page,
  input  logic [BYTE_W-1:0] cmd_vec,
  input  logic [BYTE_W-1:0] cmd_disp,
  input  logic [BYTE_W-1:0] b_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [BYTE_W-1:0] page,
  output logic [BYTE_W-1:0] rst_base,
  output logic [BYTE_W-1:0] b_out,
  output logic              b_wr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  op_e               op_in;
  op_e               op_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [BYTE_W-1:0] page_q, vec_q, disp_q, cnt_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] n_steps;
  logic              last;

  // Named events, used by the checker.
  logic accept;
  logic bad_vec;
  logic cap_lo;
  logic cap_hi;
  logic [BYTE_W-1:0] cnt_next;

  assign op_in   = op_e'(cmd_op);
  assign n_steps = op_steps(op_in);
  assign bad_vec = cmd_valid && !busy && (op_in == OP_RST) && !vec_legal(cmd_vec);
  assign accept  = cmd_valid && !busy && !bad_vec && (n_steps != '0);
  assign cap_lo  = busy && (op_q == OP_RET || op_q == OP_FRET) && (step == STEP_W'(1));
  assign cap_hi  = busy && (op_q == OP_FRET) && (step == STEP_W'(2));
  assign cnt_next = cnt_q - BYTE_W'(1);

  stack_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .n_steps (n_steps),
    .busy    (busy),
    .step    (step),
    .last    (last),
    .done    (done)
  );

  stack_seq_port u_port (
    .busy  (busy),
    .op    (op_q),
    .step  (step),
    .pc    (pc),
    .sp    (sp),
    .page  (page),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .we    (mem_we),
    .re    (mem_re)
  );

  // Operand capture.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      tgt_q  <= '0;
      page_q <= '0;
      vec_q  <= '0;
      disp_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      tgt_q  <= cmd_target;
      page_q <= cmd_page;
      vec_q  <= cmd_vec;
      disp_q <= cmd_disp;
      cnt_q  <= b_in;
    end
  end

  // Return bytes arrive one cycle after each read strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= mem_rdata;
      if (cap_hi) hi_q <= mem_rdata;
    end
  end

  // Register update at the end of the last busy cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= '0;
      sp       <= '0;
      page     <= '0;
      rst_base <= '0;
      b_out    <= '0;
      b_wr     <= 1'b0;
      err      <= 1'b0;
    end else begin
      err  <= bad_vec;
      b_wr <= 1'b0;
      if (last) begin
        case (op_q)
          OP_CALL: begin
            pc <= tgt_q;
            sp <= sp - ADDR_W'(2);
          end
          OP_FCALL: begin
            pc   <= tgt_q;
            page <= page_q;
            sp   <= sp - ADDR_W'(3);
          end
          OP_RET: begin
            pc <= {mem_rdata, lo_q};
            sp <= sp + ADDR_W'(2);
          end
          OP_FRET: begin
            pc   <= {hi_q, lo_q};
            page <= mem_rdata;
            sp   <= sp + ADDR_W'(3);
          end
          OP_RST: begin
            pc <= {rst_base, vec_q};
            sp <= sp - ADDR_W'(2);
          end
          OP_LOOP: begin
            b_out <= cnt_next;
            b_wr  <= 1'b1;
            if (cnt_next != '0) pc <= branch_pc(pc, disp_q);
          end
          OP_FJMP: begin
            pc   <= tgt_q;
            page <= page_q;
          end
          OP_SETSP:   sp       <= tgt_q;
          OP_SETBASE: rst_base <= page_q;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        bad_vec,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] pc,
  input logic [15:0] sp
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R11
  access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

  // R7
  bad_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_vec |=> (err && !busy && $stable(pc) && $stable(sp)));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (accept),
  .bad_vec (bad_vec),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .pc      (pc),
  .sp      (sp)
);

// File: tb/tb_stack_seq.sv
module tb_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_target = '0;
  logic [7:0]  cmd_page = '0, cmd_vec = '0, cmd_disp = '0, b_in = '0;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, page, rst_base, b_out;
  logic [7:0]  mem_rdata = '0;
  logic        mem_we, mem_re, b_wr, busy, done, err;

  int tests = 0;
  int fails = 0;

  logic [7:0] mem [0:255];
  logic [15:0] e_pc = '0, e_sp = '0;
  logic [7:0]  e_page = '0, e_base = '0;
  logic [15:0] ret_stack [0:15];
  logic [7:0]  page_stack [0:15];
  int          depth = 0;

  int          n_smp, nw, nr;
  logic [15:0] wa [0:3];
  logic [7:0]  wd [0:3];
  logic [15:0] ra [0:3];
  logic        first_busy, saw_bwr;
  logic [7:0]  got_b;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  stack_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cmd_page(cmd_page), .cmd_vec(cmd_vec),
    .cmd_disp(cmd_disp), .b_in(b_in), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .page(page),
    .rst_base(rst_base), .b_out(b_out), .b_wr(b_wr), .busy(busy),
    .done(done), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int op, input logic [15:0] t, input logic [7:0] pg,
                       input logic [7:0] v, input logic [7:0] d, input logic [7:0] b);
    cmd_valid = 1'b1; cmd_op = op[3:0]; cmd_target = t; cmd_page = pg;
    cmd_vec = v; cmd_disp = d; b_in = b;
  endtask

  // Called at a falling edge; returns at the falling edge of the done cycle.
  task automatic run(input int op, input logic [15:0] t, input logic [7:0] pg,
                     input logic [7:0] v, input logic [7:0] d, input logic [7:0] b,
                     input bit intrude);
    drive(op, t, pg, v, d, b);
    n_smp = 0; nw = 0; nr = 0; saw_bwr = 0; got_b = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (intrude && i == 0) drive(8, 16'h0040, 8'h00, 8'h00, 8'h00, 8'h00);
      n_smp++;
      if (i == 0) first_busy = busy;
      if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 4) begin ra[nr] = mem_addr; nr++; end
      if (b_wr) begin saw_bwr = 1; got_b = b_out; end
      if (done) break;
    end
    chk("R12 accepted in done cycle", int'(first_busy), 1);
    chk("R11 done reached", int'(done), 1);
  endtask

  task automatic do_call(input logic [15:0] t);
    run(1, t, 0, 0, 0, 0, 0);
    chk("R11 call cycles", n_smp, 3);
    chk("R2 call writes", nw, 2);
    chk("R2 call wa0", int'(wa[0]), int'(e_sp - 16'd1));
    chk("R2 call wd0", int'(wd[0]), int'(e_pc[15:8]));
    chk("R2 call wa1", int'(wa[1]), int'(e_sp - 16'd2));
    chk("R2 call wd1", int'(wd[1]), int'(e_pc[7:0]));
    ret_stack[depth] = e_pc; depth++;
    e_pc = t; e_sp = e_sp - 16'd2;
    chk("R2 call pc", int'(pc), int'(e_pc));
    chk("R2 call sp", int'(sp), int'(e_sp));
  endtask

  task automatic do_ret();
    run(3, 0, 0, 0, 0, 0, 0);
    depth--;
    chk("R11 ret cycles", n_smp, 4);
    chk("R4 ret reads", nr, 2);
    chk("R4 ret ra0", int'(ra[0]), int'(e_sp));
    chk("R4 ret ra1", int'(ra[1]), int'(e_sp + 16'd1));
    e_pc = ret_stack[depth]; e_sp = e_sp + 16'd2;
    chk("R4 ret pc", int'(pc), int'(e_pc));
    chk("R4 ret sp", int'(sp), int'(e_sp));
    chk("R4 ret no write", nw, 0);
  endtask

  task automatic do_fcall(input logic [7:0] pg, input logic [15:0] t);
    run(2, t, pg, 0, 0, 0, 0);
    chk("R11 fcall cycles", n_smp, 4);
    chk("R3 fcall writes", nw, 3);
    chk("R3 fcall wa0", int'(wa[0]), int'(e_sp - 16'd1));
    chk("R3 fcall wd0", int'(wd[0]), int'(e_page));
    chk("R3 fcall wa1", int'(wa[1]), int'(e_sp - 16'd2));
    chk("R3 fcall wd1", int'(wd[1]), int'(e_pc[15:8]));
    chk("R3 fcall wa2", int'(wa[2]), int'(e_sp - 16'd3));
    chk("R3 fcall wd2", int'(wd[2]), int'(e_pc[7:0]));
    ret_stack[depth] = e_pc; page_stack[depth] = e_page; depth++;
    e_pc = t; e_page = pg; e_sp = e_sp - 16'd3;
    chk("R3 fcall pc", int'(pc), int'(e_pc));
    chk("R3 fcall page", int'(page), int'(e_page));
    chk("R3 fcall sp", int'(sp), int'(e_sp));
  endtask

  task automatic do_fret();
    run(4, 0, 0, 0, 0, 0, 0);
    depth--;
    chk("R11 fret cycles", n_smp, 5);
    chk("R5 fret reads", nr, 3);
    for (int k = 0; k < 3; k++)
      chk("R5 fret read addr", int'(ra[k]), int'(e_sp + 16'(k)));
    e_pc = ret_stack[depth]; e_page = page_stack[depth]; e_sp = e_sp + 16'd3;
    chk("R5 fret pc", int'(pc), int'(e_pc));
    chk("R5 fret page", int'(page), int'(e_page));
    chk("R5 fret sp", int'(sp), int'(e_sp));
  endtask

  task automatic do_bad(input int op, input logic [7:0] v, input string tag, input int want_err);
    drive(op, 16'hBEEF, 8'h77, v, 8'h05, 8'h09);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " err"}, int'(err), want_err);
    chk({tag, " not busy"}, int'(busy), 0);
    chk({tag, " no access"}, int'(mem_we | mem_re), 0);
    @(negedge clk);
    chk({tag, " err cleared"}, int'(err), 0);
    chk({tag, " pc kept"}, int'(pc), int'(e_pc));
    chk({tag, " sp kept"}, int'(sp), int'(e_sp));
    chk({tag, " page kept"}, int'(page), int'(e_page));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 pc", int'(pc), 0);
    chk("R1 sp", int'(sp), 0);
    chk("R1 page", int'(page), 0);
    chk("R1 base", int'(rst_base), 0);
    chk("R1 flags", int'({busy, done, err, b_wr, mem_we, mem_re}), 0);

    // R10
    run(8, 16'h0080, 0, 0, 0, 0, 0);
    e_sp = 16'h0080;
    chk("R10 sp set", int'(sp), int'(e_sp));
    chk("R10 no access", nw + nr, 0);
    chk("R11 set cycles", n_smp, 2);
    run(9, 0, 8'h12, 0, 0, 0, 0);
    e_base = 8'h12;
    chk("R10 base set", int'(rst_base), int'(e_base));

    // R2 and R4 nested
    for (int i = 0; i < 8; i++) do_call(16'h1000 + 16'(i * 16'h0123));
    for (int i = 0; i < 8; i++) do_ret();

    // R3 and R5 nested, mixed with near forms
    do_fcall(8'h3C, 16'h4567);
    do_call(16'h2222);
    do_fcall(8'hA1, 16'hFEDC);
    do_fcall(8'h00, 16'h0001);
    do_fret();
    do_fret();
    do_ret();
    do_fret();

    // R6 and R7 sweep of every vector, two base values
    for (int v = 0; v < 256; v++) begin
      if (v == 128) begin
        run(9, 0, 8'hA5, 0, 0, 0, 0);
        e_base = 8'hA5;
      end
      if (v == 8'h10 || v == 8'h18 || v == 8'h20 || v == 8'h28 || v == 8'h38) begin
        run(5, 0, 0, 8'(v), 0, 0, 0);
        chk("R6 rst writes", nw, 2);
        chk("R6 rst wa0", int'(wa[0]), int'(e_sp - 16'd1));
        chk("R6 rst wd0", int'(wd[0]), int'(e_pc[15:8]));
        chk("R6 rst wa1", int'(wa[1]), int'(e_sp - 16'd2));
        chk("R6 rst wd1", int'(wd[1]), int'(e_pc[7:0]));
        ret_stack[depth] = e_pc; depth++;
        e_pc = {e_base, 8'(v)}; e_sp = e_sp - 16'd2;
        chk("R6 rst pc", int'(pc), int'(e_pc));
        chk("R6 rst sp", int'(sp), int'(e_sp));
        do_ret();
      end else begin
        do_bad(5, 8'(v), "R7 bad vector", 1);
      end
    end

    // R9
    run(7, 16'h8001, 8'h5A, 0, 0, 0, 0);
    e_pc = 16'h8001; e_page = 8'h5A;
    chk("R9 pc", int'(pc), int'(e_pc));
    chk("R9 page", int'(page), int'(e_page));
    chk("R9 sp kept", int'(sp), int'(e_sp));
    chk("R9 no access", nw + nr, 0);
    run(7, 16'hFFFE, 8'h01, 0, 0, 0, 0);
    e_pc = 16'hFFFE; e_page = 8'h01;
    chk("R9 pc second", int'(pc), int'(e_pc));

    // R8 sweep over displacement and counter values
    for (int bi = 0; bi < 5; bi++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] bv;
        int nb, dd;
        bv = (bi == 0) ? 8'h00 : (bi == 1) ? 8'h01 : (bi == 2) ? 8'h02 :
             (bi == 3) ? 8'h80 : 8'hFF;
        run(6, 0, 0, 0, 8'(d), bv, 0);
        nb = (int'(bv) + 255) % 256;
        dd = (d >= 128) ? d - 256 : d;
        if (nb != 0) e_pc = 16'((int'(e_pc) + dd + 65536) % 65536);
        chk("R8 b_wr", int'(saw_bwr), 1);
        chk("R8 b_out", int'(got_b), nb);
        chk("R8 pc", int'(pc), int'(e_pc));
        chk("R8 no access", nw + nr, 0);
      end
    end

    // R12 command during busy is ignored
    do_call(16'h0ABC);
    run(1, 16'h0DEF, 0, 0, 0, 0, 1);
    ret_stack[depth] = e_pc; depth++;
    e_pc = 16'h0DEF; e_sp = e_sp - 16'd2;
    chk("R12 intruder ignored sp", int'(sp), int'(e_sp));
    chk("R12 intruder ignored pc", int'(pc), int'(e_pc));
    @(negedge clk);
    chk("R12 intruder not queued", int'(busy), 0);
    do_ret();
    do_ret();
    do_bad(0, 8'h00, "R12 code 0", 0);
    do_bad(12, 8'h00, "R12 code 12", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule